// File: doc/BRIEF.md
# Bidirectional Handshake Bus Port

This block connects a host to a peripheral over one shared 8-bit bus that carries data in both directions. The host loads an output latch and takes words from an input latch. The peripheral pulls a strobe low to capture the bus value into the input latch. It pulls an acknowledge low to make the port drive the output latch onto the bus. Outside the acknowledge window the port never drives the bus. The bus is modelled as separate data-out, output-enable and data-in signals.

Each direction has its own buffer-full flag. One interrupt request is raised by either direction. For the output side, it is raised when the peripheral has taken a word. For the input side, it is raised when a strobe has completed. Each side is gated by its own enable bit.

The host sets or clears single bits of an 8-bit control port. Two of these bits are the interrupt enables and three are general-purpose outputs. The whole control port can be read back as a status view.

Top module: `bhp_port`

## Requirements
- R1: After reset, obf_n is 1, ibf is 0, irq is 0, bus_oe is 0 and cp_view equals 8'h80.
- R2: A host_wr pulse loads host_wdata into the output latch. From the next cycle, bus_dout shows that value and obf_n is 0.
- R3: bus_oe is 1 exactly while ack_n is 0, with no clock delay, and bus_dout then carries the output latch.
- R4: A cycle with ack_n low sets obf_n to 1 from the next cycle. If host_wr arrives in the same cycle, the write wins and obf_n stays 0.
- R5: In every cycle with stb_n low, the port captures bus_din into the input latch and sets ibf. host_rdata shows the last value captured. While stb_n is high, bus_din has no effect on host_rdata.
- R6: A host_rd pulse with stb_n high clears ibf and the input interrupt term from the next cycle.
- R7: On the rising edge of ack_n, if obf is clear, the output interrupt term becomes pending. A later host_wr clears the term.
- R8: On the rising edge of stb_n, the input interrupt term becomes pending.
- R9: irq equals (output term AND control bit 6) OR (input term AND control bit 4). A term that is pending while its enable is 0 shows on irq as soon as the enable is set.
- R10: A cp_wr pulse sets control bit cp_sel to cp_val when cp_sel is 6, 4, 2, 1 or 0. For cp_sel values 7, 5 and 3, the write has no effect on cp_view.
- R11: The cp_view bits are laid out as follows:
  - bit 7: obf_n
  - bit 6: output enable bit
  - bit 5: ibf
  - bit 4: input enable bit
  - bit 3: irq
  - bits 2..0: the general-purpose outputs

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the output latch |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe for the input latch |
| host_rdata | output | 8 | Input latch contents |
| cp_wr | input | 1 | Control-port single-bit write |
| cp_sel | input | 3 | Control-port bit index |
| cp_val | input | 1 | Value written to the selected bit |
| cp_view | output | 8 | Control-port status view |
| bus_din | input | 8 | Peripheral bus value seen by the port |
| bus_dout | output | 8 | Value the port drives on the bus |
| bus_oe | output | 1 | Bus driver enable (low means high-impedance) |
| stb_n | input | 1 | Active-low peripheral strobe |
| ack_n | input | 1 | Active-low peripheral acknowledge |
| obf_n | output | 1 | Active-low output buffer full |
| ibf | output | 1 | Input buffer full |
| irq | output | 1 | Interrupt request |

## Verification
The output side is exercised three ways:
- A plain write followed by an acknowledge pulse checks the driver window and the clearing of buffer-full.
- A write that lands in the same cycle as an acknowledge separates write priority from acknowledge clearing.
- An acknowledge completed while the output enable is off shows that a pending term is kept and later unmasked.

The input side changes the bus while the strobe is held low and again after it is released. This separates capture-while-low from capture-on-edge, and the read step separates flag clearing from the data value. Control-port writes to the status-only positions check that those bits cannot be forced. A continuous monitor flags any cycle where the drivers are on while acknowledge is inactive.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
  localparam int CP_W       = 8;
  localparam int SEL_W      = $clog2(CP_W);
  localparam int GP_N       = 3;
  localparam int OBF_POS    = 7;
  localparam int IE_OUT_POS = 6;
  localparam int IBF_POS    = 5;
  localparam int IE_IN_POS  = 4;
  localparam int IRQ_POS    = 3;
endpackage

// File: rtl/bhp_rx.sv
module bhp_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_n,
  input  logic [DW-1:0] bus_din,
  input  logic          host_rd,
  output logic [DW-1:0] in_data,
  output logic          ibf,
  output logic          in_pend
);
  logic stb_d;
  logic stb_rise;

  assign stb_rise = ~stb_d & stb_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_d   <= 1'b1;
      in_data <= '0;
      ibf     <= 1'b0;
      in_pend <= 1'b0;
    end else begin
      stb_d <= stb_n;
      if (!stb_n) begin
        in_data <= bus_din;
        ibf     <= 1'b1;
      end else if (host_rd) begin
        ibf <= 1'b0;
      end
      if (stb_rise) in_pend <= 1'b1;
      if (host_rd && stb_n) in_pend <= 1'b0;
    end
  end

  // R5
  ibf_set_chk: assert property (@(posedge clk) disable iff (rst)
    !stb_n |=> (ibf && in_data == $past(bus_din)));

  // R6
  ibf_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && stb_n) |=> (!ibf && !in_pend));

  // R8
  in_pend_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_pend) |-> $past(stb_n) && !$past(stb_n, 2));
endmodule

// File: rtl/bhp_tx.sv
module bhp_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_n,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          obf,
  output logic          out_pend
);
  logic ack_d;
  logic ack_rise;

  assign ack_rise = ~ack_d & ack_n;
  assign bus_oe   = ~ack_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_d    <= 1'b1;
      bus_dout <= '0;
      obf      <= 1'b0;
      out_pend <= 1'b0;
    end else begin
      ack_d <= ack_n;
      if (host_wr) begin
        bus_dout <= host_wdata;
        obf      <= 1'b1;
        out_pend <= 1'b0;
      end else begin
        if (!ack_n) obf <= 1'b0;
        if (ack_rise && !obf) out_pend <= 1'b1;
      end
    end
  end

  // R2
  obf_set_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> (obf && bus_dout == $past(host_wdata)));

  // R4
  obf_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && !host_wr) |=> !obf);

  // R7
  out_pend_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_pend) |-> $past(!ack_d));
endmodule

// File: rtl/bhp_ctrl.sv
module bhp_ctrl
  import bhp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cp_wr,
  input  logic [SEL_W-1:0] cp_sel,
  input  logic             cp_val,
  input  logic             obf,
  input  logic             ibf,
  input  logic             out_pend,
  input  logic             in_pend,
  output logic             irq,
  output logic [CP_W-1:0]  cp_view
);
  logic            ie_out;
  logic            ie_in;
  logic [GP_N-1:0] gp;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_out <= 1'b0;
      ie_in  <= 1'b0;
    end else if (cp_wr) begin
      if (cp_sel == SEL_W'(IE_OUT_POS)) ie_out <= cp_val;
      if (cp_sel == SEL_W'(IE_IN_POS))  ie_in  <= cp_val;
    end
  end

  for (genvar g = 0; g < GP_N; g++) begin : g_gp
    always_ff @(posedge clk) begin
      if (rst)                                 gp[g] <= 1'b0;
      else if (cp_wr && cp_sel == SEL_W'(g))   gp[g] <= cp_val;
    end
  end

  assign irq = (out_pend & ie_out) | (in_pend & ie_in);

  always_comb begin
    cp_view             = '0;
    cp_view[OBF_POS]    = ~obf;
    cp_view[IE_OUT_POS] = ie_out;
    cp_view[IBF_POS]    = ibf;
    cp_view[IE_IN_POS]  = ie_in;
    cp_view[IRQ_POS]    = irq;
    cp_view[GP_N-1:0]   = gp;
  end

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((ie_out && out_pend) || (ie_in && in_pend)));

  // R10
  gp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cp_wr |=> $stable(gp) && $stable(ie_out) && $stable(ie_in));
endmodule

// File: rtl/bhp_port.sv
module bhp_port
  import bhp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_rd,
  output logic [DW-1:0]    host_rdata,
  input  logic             cp_wr,
  input  logic [SEL_W-1:0] cp_sel,
  input  logic             cp_val,
  output logic [CP_W-1:0]  cp_view,
  input  logic [DW-1:0]    bus_din,
  output logic [DW-1:0]    bus_dout,
  output logic             bus_oe,
  input  logic             stb_n,
  input  logic             ack_n,
  output logic             obf_n,
  output logic             ibf,
  output logic             irq
);
  logic obf;
  logic out_pend;
  logic in_pend;

  bhp_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .ack_n(ack_n), .host_wr(host_wr),
    .host_wdata(host_wdata), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .obf(obf), .out_pend(out_pend)
  );

  bhp_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .stb_n(stb_n), .bus_din(bus_din),
    .host_rd(host_rd), .in_data(host_rdata), .ibf(ibf), .in_pend(in_pend)
  );

  bhp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cp_wr(cp_wr), .cp_sel(cp_sel), .cp_val(cp_val),
    .obf(obf), .ibf(ibf), .out_pend(out_pend), .in_pend(in_pend),
    .irq(irq), .cp_view(cp_view)
  );

  assign obf_n = ~obf;

  // R3
  oe_window_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (!ack_n && bus_dout == host_wdata_seen));

  logic [DW-1:0] host_wdata_seen;
  always_ff @(posedge clk) begin
    if (rst)          host_wdata_seen <= '0;
    else if (host_wr) host_wdata_seen <= host_wdata;
  end
endmodule

// File: tb/bhp_port_tb.sv
module bhp_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0, cp_wr = 1'b0, cp_val = 1'b0;
  logic [7:0] host_wdata = '0, bus_din = '0;
  logic [2:0] cp_sel = '0;
  logic       stb_n = 1'b1, ack_n = 1'b1;
  logic [7:0] host_rdata, cp_view, bus_dout;
  logic       bus_oe, obf_n, ibf, irq;

  int checks = 0;
  int fails  = 0;
  int oe_viol = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bhp_port u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .cp_wr(cp_wr),
    .cp_sel(cp_sel), .cp_val(cp_val), .cp_view(cp_view),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .stb_n(stb_n), .ack_n(ack_n), .obf_n(obf_n), .ibf(ibf), .irq(irq)
  );

  // R3: drivers must never be on while acknowledge is inactive
  always @(negedge clk) if (!rst && bus_oe && ack_n) oe_viol++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cp_set(input int bitpos, input logic v);
    cp_wr = 1'b1; cp_sel = 3'(bitpos); cp_val = v;
    cyc();
    cp_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 obf_n", obf_n, 1);
    chk("R1 ibf", ibf, 0);
    chk("R1 irq", irq, 0);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 cp_view", cp_view, 8'h80);
  endtask

  task automatic t_write_ack();
    host_wr = 1'b1; host_wdata = 8'hA5;
    cyc();
    host_wr = 1'b0;
    chk("R2 obf_n after write", obf_n, 0);
    chk("R2 bus_dout", bus_dout, 8'hA5);
    chk("R3 oe off without ack", bus_oe, 0);
    ack_n = 1'b0; #1;
    chk("R3 oe on with ack", bus_oe, 1);
    chk("R3 data driven", bus_dout, 8'hA5);
    cyc();
    chk("R4 obf_n cleared by ack", obf_n, 1);
    ack_n = 1'b1; #1;
    chk("R3 oe off after ack", bus_oe, 0);
    cyc();
    chk("R9 masked output term", irq, 0);
    cp_set(6, 1'b1);
    chk("R9 pending shows after enable", irq, 1);
    chk("R11 cp_view ie_out+irq", cp_view, 8'hC8);
    host_wr = 1'b1; host_wdata = 8'h3C;
    cyc();
    host_wr = 1'b0;
    chk("R7 write clears output term", irq, 0);
  endtask

  task automatic t_out_irq();
    ack_n = 1'b0; cyc();
    ack_n = 1'b1; cyc();
    chk("R7 output term after ack rise", irq, 1);
    host_wr = 1'b1; host_wdata = 8'hC3; ack_n = 1'b0;
    cyc();
    host_wr = 1'b0; ack_n = 1'b1;
    chk("R4 write wins over ack", obf_n, 0);
    chk("R7 write cleared term", irq, 0);
    cyc();
    chk("R7 no term while obf set", irq, 0);
    chk("R4 obf stays", obf_n, 0);
    cp_set(6, 1'b0);
  endtask

  task automatic t_strobe();
    bus_din = 8'h5A; stb_n = 1'b0;
    cyc();
    chk("R5 ibf set", ibf, 1);
    chk("R5 captured", host_rdata, 8'h5A);
    bus_din = 8'h77;
    cyc();
    chk("R5 follows while low", host_rdata, 8'h77);
    stb_n = 1'b1;
    cyc();
    chk("R9 input term masked", irq, 0);
    bus_din = 8'h11;
    cyc();
    chk("R5 ignored while high", host_rdata, 8'h77);
    cp_set(4, 1'b1);
    chk("R8 input term after strobe rise", irq, 1);
    host_rd = 1'b1;
    cyc();
    host_rd = 1'b0;
    chk("R6 ibf cleared", ibf, 0);
    chk("R6 input term cleared", irq, 0);
    chk("R6 data kept", host_rdata, 8'h77);
  endtask

  task automatic t_ctrl();
    cp_set(2, 1'b1);
    cp_set(0, 1'b1);
    chk("R10 gp bits", cp_view[2:0], 3'b101);
    cp_set(7, 1'b1);
    chk("R10 bit7 ignored", cp_view[7], 0);
    cp_set(5, 1'b1);
    chk("R10 bit5 ignored", cp_view[5], 0);
    cp_set(3, 1'b1);
    chk("R10 bit3 ignored", cp_view[3], 0);
    cp_set(1, 1'b1);
    cp_set(1, 1'b0);
    chk("R10 gp clear", cp_view[2:0], 3'b101);
    bus_din = 8'h9E; stb_n = 1'b0; cyc();
    stb_n = 1'b1; cyc();
    chk("R11 composite view", cp_view, 8'h3D);
    chk("R8 irq", irq, 1);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    t_reset();
    t_write_ack();
    t_out_irq();
    t_strobe();
    t_ctrl();
    chk("R3 oe never without ack", oe_viol, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule